// File: doc/BRIEF.md
# Shared ALU with Branch Condition Evaluation

This block is the single arithmetic unit of a 16-bit multi-cycle processor. One instance serves every arithmetic step in the pipeline: incrementing the program counter, forming load/store addresses and branch targets, adding immediates, and running the register-to-register operations. It is purely combinational, has no internal state, and all arithmetic wraps modulo 2^16.

The same unit also decides conditional branches. For a branch operation it subtracts operand B from operand A. From that difference it raises a taken flag for one of six signed comparisons. Operands that come from a 4-bit instruction field can be sign-extended inside the block before use, so that a constant such as `1100` acts as -4. A zero flag reports an all-zero result for every operation.

Top module: `alu_branch_unit`

## Requirements
- R1: Operation code 0 produces `result_o = a + b_eff` modulo 2^16, where `b_eff` is the effective B operand (see R5). For example, 16'h7FFF + 1 gives 16'h8000 and 16'hFFFF + 1 gives 16'h0000.
- R2: Operation code 1 produces `result_o = a - b_eff` modulo 2^16.
- R3: Operation code 2 produces the bitwise AND of A and `b_eff`. Operation code 3 produces their bitwise OR.
- R4: Operation code 4 (hold) drives `result_o` to 16'h0000 and `taken_o` to 0, whatever the operands are.
- R5: When `imm_en_i` is 1, `b_eff` is `b_i[3:0]` sign-extended to 16 bits, and `b_i[15:4]` has no effect. When `imm_en_i` is 0, `b_eff` equals `b_i`.
- R6: Code 8 (equal) sets `taken_o` exactly when A equals `b_eff`. Code 9 (not equal) sets it exactly when they differ.
- R7: Code 10 (less than) and code 13 (greater or equal) compare A with `b_eff` as signed two's-complement values and set `taken_o` accordingly.
- R8: Code 11 (less or equal) and code 12 (greater than) compare A with `b_eff` as signed two's-complement values and set `taken_o` accordingly.
- R9: `zero_o` is 1 exactly when `result_o` is 16'h0000.
- R10: For codes 0 to 4, `taken_o` is 0. For the unused codes 5, 6, 7, 14 and 15, `result_o` is 16'h0000 and `taken_o` is 0.
- R11: For the branch codes 8 to 13, `result_o` is `a - b_eff` modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation / branch condition select |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B, or a 4-bit field in bits [3:0] |
| imm_en_i | input | 1 | Sign-extend `b_i[3:0]` and use it as operand B |
| result_o | output | 16 | Operation result |
| zero_o | output | 1 | Result is all zeros |
| taken_o | output | 1 | The selected branch condition holds |

## Verification
The bench targets the points where signed and unsigned ordering disagree: 16'h7FFF against 16'h8000, and small positives against 16'hFFFF. A design that compared unsigned, or took only the sign of the difference, would report these the wrong way round. It checks equal operands under LE, GE and GT, where an off-by-one in the condition flips the taken flag. It also checks sign extension with the top nibble bits both set and clear, and with junk in `b_i[15:4]`; a zero-extending or unmasked path would show up as a wrong sum. Carry-out wraps, the hold code and the unused codes are covered too, so a design that let a stale result or a taken flag leak through would be caught.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned IMM_W  = 4;
  localparam int unsigned OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_HOLD = 4'd4,
    OP_BEQ  = 4'd8,
    OP_BNE  = 4'd9,
    OP_BLT  = 4'd10,
    OP_BLE  = 4'd11,
    OP_BGT  = 4'd12,
    OP_BGE  = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic eq;
    logic lt;
  } cmp_flags_t;
endpackage

// File: rtl/alu_sext.sv
module alu_sext #(
  parameter int unsigned IN_W  = 4,
  parameter int unsigned OUT_W = 16
) (
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] val_o
);
  localparam int unsigned EXT_W = OUT_W - IN_W;

  generate
    if (EXT_W == 0) begin : g_pass
      assign val_o = val_i;
    end else begin : g_ext
      assign val_o = {{EXT_W{val_i[IN_W-1]}}, val_i};
    end
  endgenerate
endmodule

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o
);
  assign sum_o  = a_i + b_i;
  assign diff_o = a_i - b_i;
  assign and_o  = a_i & b_i;
  assign or_o   = a_i | b_i;
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] diff_i,
  output cmp_flags_t   flags_o
);
  logic sign_differs;

  // signed less-than: operand signs decide when they differ, otherwise the difference sign
  assign sign_differs = a_i[W-1] ^ b_i[W-1];
  assign flags_o.lt   = sign_differs ? a_i[W-1] : diff_i[W-1];
  assign flags_o.eq   = (diff_i == '0);
endmodule

// File: rtl/alu_branch_unit.sv
module alu_branch_unit
  import alu_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned IMM_N = IMM_W
) (
  input  logic [OP_W-1:0] op_i,
  input  logic [W-1:0]    a_i,
  input  logic [W-1:0]    b_i,
  input  logic            imm_en_i,
  output logic [W-1:0]    result_o,
  output logic            zero_o,
  output logic            taken_o
);
  logic [W-1:0] imm_ext;
  logic [W-1:0] b_eff;
  logic [W-1:0] sum, diff, and_v, or_v;
  cmp_flags_t   flags;

  alu_sext #(.IN_W(IMM_N), .OUT_W(W)) u_sext (
    .val_i (b_i[IMM_N-1:0]),
    .val_o (imm_ext)
  );

  assign b_eff = imm_en_i ? imm_ext : b_i;

  alu_arith #(.W(W)) u_arith (
    .a_i    (a_i),
    .b_i    (b_eff),
    .sum_o  (sum),
    .diff_o (diff),
    .and_o  (and_v),
    .or_o   (or_v)
  );

  alu_cmp #(.W(W)) u_cmp (
    .a_i     (a_i),
    .b_i     (b_eff),
    .diff_i  (diff),
    .flags_o (flags)
  );

  always_comb begin
    result_o = '0;
    taken_o  = 1'b0;
    case (op_i)
      OP_ADD:  result_o = sum;
      OP_SUB:  result_o = diff;
      OP_AND:  result_o = and_v;
      OP_OR:   result_o = or_v;
      OP_HOLD: result_o = '0;
      OP_BEQ: begin result_o = diff; taken_o = flags.eq;              end
      OP_BNE: begin result_o = diff; taken_o = ~flags.eq;             end
      OP_BLT: begin result_o = diff; taken_o = flags.lt;              end
      OP_BLE: begin result_o = diff; taken_o = flags.lt | flags.eq;   end
      OP_BGT: begin result_o = diff; taken_o = ~(flags.lt | flags.eq); end
      OP_BGE: begin result_o = diff; taken_o = ~flags.lt;             end
      default: begin result_o = '0; taken_o = 1'b0;                   end
    endcase
  end

  assign zero_o = (result_o == '0);
endmodule

// File: rtl/alu_branch_unit_chk.sv
module alu_branch_unit_chk
  import alu_pkg::*;
#(
  parameter int unsigned W     = DATA_W,
  parameter int unsigned IMM_N = IMM_W
) (
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic            imm_en_i,
  input logic [W-1:0]    result_o,
  input logic            zero_o,
  input logic            taken_o
);
  logic known;
  assign known = !$isunknown({op_i, a_i, b_i, imm_en_i});

  always_comb begin
    if (known) begin
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R9
      AST_HOLD_CLEAR: assert (op_i != OP_HOLD || (result_o == '0 && !taken_o)); // R4
      AST_NO_TAKEN_NONBR: assert (op_i >= 4'd8 && op_i <= 4'd13 || !taken_o); // R10
      AST_EQ_TRACKS_ZERO: assert (op_i != OP_BEQ || taken_o == zero_o); // R6
      AST_NE_INVERTS_ZERO: assert (op_i != OP_BNE || taken_o == !zero_o); // R6
    end
  end
endmodule

bind alu_branch_unit alu_branch_unit_chk #(.W(W), .IMM_N(IMM_N)) u_chk (.*);

// File: tb/alu_branch_unit_tb.sv
module alu_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  op_i = '0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        imm_en_i = 1'b0;
  logic [15:0] result_o;
  logic        zero_o;
  logic        taken_o;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  alu_branch_unit u_dut (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_en_i(imm_en_i),
    .result_o(result_o), .zero_o(zero_o), .taken_o(taken_o)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic        imm;
    logic [15:0] a;
    logic [15:0] b;
    logic [15:0] res;
    logic        z;
    logic        t;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  1'b0, 16'h0002, 16'h0002, 16'h0004, 1'b0, 1'b0, 4'd1},  // R1
    '{4'd0,  1'b0, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0, 4'd1},  // R1 wrap
    '{4'd0,  1'b1, 16'h0000, 16'hABCC, 16'hFFFC, 1'b0, 1'b0, 4'd5},  // R5 -4
    '{4'd0,  1'b1, 16'h0000, 16'h0002, 16'h0002, 1'b0, 1'b0, 4'd5},  // R5
    '{4'd0,  1'b1, 16'h0005, 16'hFFF7, 16'h000C, 1'b0, 1'b0, 4'd5},  // R5 junk upper
    '{4'd1,  1'b0, 16'h0004, 16'h0002, 16'h0002, 1'b0, 1'b0, 4'd2},  // R2
    '{4'd1,  1'b0, 16'h0002, 16'h0004, 16'hFFFE, 1'b0, 1'b0, 4'd2},  // R2
    '{4'd1,  1'b0, 16'h8000, 16'h0001, 16'h7FFF, 1'b0, 1'b0, 4'd2},  // R2
    '{4'd2,  1'b0, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd3,  1'b0, 16'hF0F0, 16'h0F0F, 16'hFFFF, 1'b0, 1'b0, 4'd3},  // R3
    '{4'd2,  1'b0, 16'h00FF, 16'hFF00, 16'h0000, 1'b1, 1'b0, 4'd9},  // R9
    '{4'd4,  1'b0, 16'h1234, 16'h5678, 16'h0000, 1'b1, 1'b0, 4'd4},  // R4
    '{4'd8,  1'b0, 16'h0004, 16'h0004, 16'h0000, 1'b1, 1'b1, 4'd6},  // R6
    '{4'd8,  1'b0, 16'h0004, 16'h0002, 16'h0002, 1'b0, 1'b0, 4'd6},  // R6
    '{4'd9,  1'b0, 16'h0004, 16'h0002, 16'h0002, 1'b0, 1'b1, 4'd6},  // R6
    '{4'd9,  1'b0, 16'h7777, 16'h7777, 16'h0000, 1'b1, 1'b0, 4'd6},  // R6
    '{4'd10, 1'b0, 16'hFFFE, 16'h0002, 16'hFFFC, 1'b0, 1'b1, 4'd7},  // R7
    '{4'd10, 1'b0, 16'h7FFF, 16'h8000, 16'hFFFF, 1'b0, 1'b0, 4'd7},  // R7 signed
    '{4'd13, 1'b0, 16'h8000, 16'h7FFF, 16'h0001, 1'b0, 1'b0, 4'd7},  // R7 signed
    '{4'd13, 1'b0, 16'h0003, 16'h0003, 16'h0000, 1'b1, 1'b1, 4'd7},  // R7 equal
    '{4'd11, 1'b0, 16'h0003, 16'h0003, 16'h0000, 1'b1, 1'b1, 4'd8},  // R8 equal
    '{4'd11, 1'b0, 16'h0005, 16'hFFFF, 16'h0006, 1'b0, 1'b0, 4'd8},  // R8
    '{4'd12, 1'b0, 16'h0005, 16'hFFFF, 16'h0006, 1'b0, 1'b1, 4'd8},  // R8
    '{4'd12, 1'b0, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b0, 4'd8},  // R8 equal
    '{4'd12, 1'b1, 16'h0000, 16'h000E, 16'h0002, 1'b0, 1'b1, 4'd11}, // R11 imm -2
    '{4'd5,  1'b0, 16'h1234, 16'h0001, 16'h0000, 1'b1, 1'b0, 4'd10}, // R10
    '{4'd15, 1'b0, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b0, 4'd10}, // R10
    '{4'd10, 1'b1, 16'hFFFC, 16'h0008, 16'h0004, 1'b0, 1'b0, 4'd5}   // R5 -8
  };

  task automatic apply_check(input logic [3:0] op, input logic imm,
                             input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] res, input logic z,
                             input logic t, input int req);
    @(negedge clk);
    op_i = op; imm_en_i = imm; a_i = a; b_i = b;
    #2;
    n_chk++;
    if (result_o !== res || zero_o !== z || taken_o !== t) begin
      n_fail++;
      $display("FAIL R%0d op=%0d a=%h b=%h imm=%b: got res=%h z=%b t=%b, exp res=%h z=%b t=%b",
               req, op, a, b, imm, result_o, zero_o, taken_o, res, z, t);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    // reset state: zero inputs give zero result (R9, R1)
    apply_check(4'd0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 9);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++)
      apply_check(VECS[i].op, VECS[i].imm, VECS[i].a, VECS[i].b,
                  VECS[i].res, VECS[i].z, VECS[i].t, int'(VECS[i].req));
    // R1 signed overflow wraps
    apply_check(4'd0, 1'b0, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b0, 1);
    // R11 branch result is the difference
    apply_check(4'd8, 1'b0, 16'h0010, 16'h0001, 16'h000F, 1'b0, 1'b0, 11);
    // R10 add never sets taken, even with equal operands
    apply_check(4'd0, 1'b0, 16'h0003, 16'h0003, 16'h0006, 1'b0, 1'b0, 10);
    // R5 imm off: full B used
    apply_check(4'd0, 1'b0, 16'h0000, 16'hABCC, 16'hABCC, 1'b0, 1'b0, 5);
    // R4 hold with a taken-prone pair
    apply_check(4'd4, 1'b1, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0, 4);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule